// File: doc/BRIEF.md
# SPI Slave Serial Port with Frame Resynchronisation

This block is the slave side of an SPI link. It moves 8-bit characters in both directions, MSB first. The external master's serial clock sets the bit timing. The chip's system clock samples that serial clock, the slave enable and the data input through two-flop synchronisers. Shifting happens on the edges detected in those synchronised signals.

Software picks the clock polarity and phase to match the master. It also picks one of two modes:
- **3-wire mode:** the port shifts whenever it is out of soft reset.
- **4-wire mode:** the active-low enable line gates shifting.

Each completed receive byte is written to a holding register. It also sets a receive flag and produces a one-cycle DMA request. A one-byte transmit buffer feeds the output shifter.

Partial characters are always thrown away. This happens when the soft-reset input is held, and in 4-wire mode whenever the enable line goes inactive. Leftover bits from a master that clocks past its last full byte can therefore never shift the bit alignment of the next stream.

Top module: `spi_slave_port`

## Requirements
- R1: Eight sampling edges move the MOSI bits, first bit into bit 7, into `rx_data`. The same edge that completes the byte sets `rx_flag`.
- R2: Reception is correct in all four settings of `cpol` and `cpha`. With `cpha`=0, data is sampled on the edge leaving the idle level (`cpol`). With `cpha`=1, it is sampled on the edge returning to it.
- R3: Every completed byte raises `dma_req` for exactly one system clock cycle, and `rx_flag` is high in that cycle.
- R4: If a byte completes while `rx_flag` is still set, `overrun` is set and `rx_data` takes the new byte.
- R5: Pulsing `rx_rd` clears `rx_flag`.
- R6: While `soft_rst` is high, the following are cleared: `rx_flag`, `overrun`, `frame_err`, both interrupt enables, the bit counter, both shifters and the transmit buffer. `tx_ready` is set. A byte sent after release is received aligned, even if a partial byte was in progress before the reset.
- R7: In 4-wire mode (`four_wire`=1), serial clock edges are ignored while `cs_n` is high. Shifting happens only while it is low.
- R8: In 4-wire mode, a rise of `cs_n` discards any partial byte and empties the transmit buffer. If bits were pending, `frame_err` is set. The next frame starts at bit 0.
- R9: Changing `cpol` while the serial clock is still does not count as an edge. Edges seen while `soft_rst` is high are never counted.
- R10: A byte written with `tx_load` drives `miso` MSB first during the next character, and `tx_ready` reads 0 until that character's first sampling edge. An empty buffer sends zeros.
- R11: `rx_irq` equals `rx_flag` AND receive enable. `tx_irq` equals `tx_ready` AND transmit enable. The enables are written by `ie_wr`: bit 0 of `ie_din` is the receive enable and bit 1 is the transmit enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset: holds the port idle and cleared |
| four_wire | input | 1 | 1 = the enable line gates shifting |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low slave enable (4-wire mode) |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| tx_load | input | 1 | Write `tx_data` into the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Acknowledge the received byte (clears `rx_flag`) |
| rx_data | output | 8 | Last completed receive byte |
| ie_wr | input | 1 | Write the interrupt enables |
| ie_din | input | 2 | Bit 0 = receive enable, bit 1 = transmit enable |
| rx_flag | output | 1 | Unread received byte present |
| tx_ready | output | 1 | Transmit buffer empty |
| overrun | output | 1 | A byte was overwritten before being read |
| frame_err | output | 1 | Enable line released in the middle of a byte |
| dma_req | output | 1 | One-cycle pulse per completed byte |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The main test is an exhaustive sweep. Every byte value 0x00 to 0xFF is received under each of the four polarity/phase settings. This exposes a swapped sampling edge, a reversed bit order and a dropped or duplicated bit. Each setting on its own would hide some of those faults, because certain values are symmetric under them.

Truncated streams of 3 and 5 bits are followed by either a soft reset or an enable release, and then by a full byte. This separates correct discarding from a design that carries leftover bits forward. A polarity flip with the clock held still shows whether edge detection follows the raw pin or the polarity-adjusted level. Transmit bytes are captured from `miso` in every mode, and their value changes from mode to mode, so a stale buffer is caught.

// File: rtl/spi_slave_port.sv
module spi_slave_port #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          four_wire,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_data,
  input  logic          ie_wr,
  input  logic [1:0]    ie_din,
  output logic          rx_flag,
  output logic          tx_ready,
  output logic          overrun,
  output logic          frame_err,
  output logic          dma_req,
  output logic          rx_irq,
  output logic          tx_irq
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [SYNC-1:0] sclk_q, cs_q, mosi_q;
  logic            sclk_p, cs_p;
  logic [CW-1:0]   bitcnt;
  logic [DW-1:0]   rx_sh, tx_sh, tx_buf;
  logic [1:0]      ie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_p <= 1'b0;
      cs_p   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC-2:0], sclk};
      cs_q   <= {cs_q[SYNC-2:0], cs_n};
      mosi_q <= {mosi_q[SYNC-2:0], mosi};
      sclk_p <= sclk_q[SYNC-1];
      cs_p   <= cs_q[SYNC-1];
    end

  wire sclk_s = sclk_q[SYNC-1];
  wire cs_s   = cs_q[SYNC-1];
  wire rise   = sclk_s & ~sclk_p;
  wire fall   = ~sclk_s & sclk_p;
  wire lead   = cpol ? fall : rise;
  wire trail  = cpol ? rise : fall;
  wire cs_end = four_wire & cs_s & ~cs_p;
  wire active = ~soft_rst & (~four_wire | ~cs_s);
  wire samp   = active & (cpha ? trail : lead);
  wire shft   = active & (cpha ? lead : trail) & (bitcnt != '0);
  wire last   = samp & (bitcnt == LAST_BIT);
  wire [DW-1:0] rx_next = {rx_sh[DW-2:0], mosi_q[SYNC-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      tx_buf    <= '0;
      rx_data   <= '0;
      tx_ready  <= 1'b1;
      rx_flag   <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
      dma_req   <= 1'b0;
      ie        <= '0;
    end else if (soft_rst) begin
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      tx_buf    <= '0;
      tx_ready  <= 1'b1;
      rx_flag   <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
      dma_req   <= 1'b0;
      ie        <= '0;
    end else begin
      dma_req <= last;
      if (ie_wr) ie <= ie_din;
      if (rx_rd) rx_flag <= 1'b0;
      if (cs_end) begin
        bitcnt   <= '0;
        rx_sh    <= '0;
        tx_sh    <= '0;
        tx_buf   <= '0;
        tx_ready <= 1'b1;
        if (bitcnt != '0) frame_err <= 1'b1;
      end else begin
        if (samp) begin
          rx_sh  <= rx_next;
          bitcnt <= last ? '0 : bitcnt + 1'b1;
          if (bitcnt == '0) tx_ready <= 1'b1;
        end
        if (last) begin
          rx_data <= rx_next;
          rx_flag <= 1'b1;
          if (rx_flag && !rx_rd) overrun <= 1'b1;
        end
        if (shft)               tx_sh <= {tx_sh[DW-2:0], 1'b0};
        else if (bitcnt == '0) tx_sh <= tx_ready ? '0 : tx_buf;
      end
      if (tx_load) begin
        tx_buf   <= tx_data;
        tx_ready <= 1'b0;
      end
    end

  assign miso   = tx_sh[DW-1];
  assign rx_irq = rx_flag & ie[0];
  assign tx_irq = tx_ready & ie[1];

  p_dma_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);
  p_dma_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rx_flag);
  p_ovr_on_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> dma_req);
  p_soft_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!rx_flag && tx_ready && !overrun && !frame_err && !rx_irq && !tx_irq && bitcnt == '0));
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (four_wire && cs_s) |=> $stable(rx_data));
  p_cs_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && !soft_rst) |=> (bitcnt == '0 && tx_ready));
endmodule

// File: tb/sim_spi_slave_port.sv
module sim_spi_slave_port;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam int H = 4;
  logic rst_n, soft_rst, four_wire, cpol, cpha, sclk, cs_n, mosi, miso;
  logic tx_load, rx_rd, ie_wr;
  logic [7:0] tx_data, rx_data, mo;
  logic [1:0] ie_din;
  logic rx_flag, tx_ready, overrun, frame_err, dma_req, rx_irq, tx_irq;
  int n_chk = 0, n_bad = 0, dma_cnt = 0;

  spi_slave_port u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .four_wire(four_wire),
    .cpol(cpol), .cpha(cpha), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .tx_load(tx_load), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .ie_wr(ie_wr), .ie_din(ie_din), .rx_flag(rx_flag), .tx_ready(tx_ready),
    .overrun(overrun), .frame_err(frame_err), .dma_req(dma_req),
    .rx_irq(rx_irq), .tx_irq(tx_irq));

  always @(posedge clk) if (rst_n && dma_req) dma_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input int n);
    mo = 8'h00;
    for (int i = 0; i < n; i++) begin
      if (!cpha) begin
        mosi = b[7-i];
        half();
        mo[7-i] = miso;
        sclk = ~cpol;
        half();
        sclk = cpol;
      end else begin
        sclk = ~cpol;
        @(negedge clk);
        mosi = b[7-i];
        repeat (H-2) @(negedge clk);
        mo[7-i] = miso;
        @(negedge clk);
        sclk = cpol;
        half();
      end
    end
    half();
  endtask

  task automatic rd();
    @(negedge clk) rx_rd = 1'b1;
    @(negedge clk) rx_rd = 1'b0;
  endtask

  task automatic setmode(input logic pol, input logic pha, input logic fw);
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk);
    cpol = pol; cpha = pha; four_wire = fw; sclk = pol;
    repeat (4) @(negedge clk);
    soft_rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    rst_n = 0; soft_rst = 1; four_wire = 0; cpol = 0; cpha = 0; sclk = 0;
    cs_n = 1; mosi = 0; tx_load = 0; tx_data = 0; rx_rd = 0; ie_wr = 0; ie_din = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!rx_flag && tx_ready && !overrun && !frame_err && dma_cnt == 0, "R6 reset state",
        {rx_flag, tx_ready, overrun, frame_err}, 4'b0100);

    // R1 R2: every byte in every mode
    for (int m = 0; m < 4; m++) begin
      setmode(m[1], m[0], 1'b0);
      for (int b = 0; b < 256; b++) begin
        send(8'(b), 8);
        chk(rx_data == 8'(b) && rx_flag, "R2 mode sweep (R1 MSB first)", rx_data, b);
        rd();
        if (b == 0) chk(!rx_flag, "R5 read clears flag", rx_flag, 0);
      end
    end
    chk(dma_cnt == 1024, "R3 one DMA pulse per byte", dma_cnt, 1024);

    setmode(1'b0, 1'b0, 1'b0);
    send(8'h11, 8);
    send(8'h22, 8);
    chk(overrun == 1'b1, "R4 overrun set", overrun, 1);
    chk(rx_data == 8'h22, "R4 buffer overwritten", rx_data, 8'h22);
    setmode(1'b0, 1'b0, 1'b0);
    chk(!overrun && !rx_flag && tx_ready, "R6 soft reset clears flags",
        {overrun, rx_flag, tx_ready}, 3'b001);

    @(negedge clk) begin ie_wr = 1; ie_din = 2'b11; end
    @(negedge clk) ie_wr = 0;
    send(8'h5A, 8);
    chk(rx_irq == 1'b1, "R11 receive interrupt", rx_irq, 1);
    chk(tx_irq == 1'b1, "R11 transmit interrupt", tx_irq, 1);
    rd();
    chk(rx_irq == 1'b0, "R11 receive interrupt follows flag", rx_irq, 0);
    setmode(1'b0, 1'b0, 1'b0);
    chk(!rx_irq && !tx_irq, "R6 enables cleared", {rx_irq, tx_irq}, 0);

    send(8'hFF, 3);
    chk(!rx_flag, "R6 partial byte not delivered", rx_flag, 0);
    setmode(1'b0, 1'b0, 1'b0);
    send(8'hA5, 8);
    chk(rx_data == 8'hA5, "R6 aligned after soft reset", rx_data, 8'hA5);
    rd();

    setmode(1'b0, 1'b0, 1'b0);
    begin
      int d0;
      d0 = dma_cnt;
      @(negedge clk) cpol = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      send(8'h81, 8);
      chk(rx_data == 8'h81 && dma_cnt == d0 + 1, "R9 polarity change counts no edge",
          rx_data, 8'h81);
    end
    rd();

    cs_n = 1;
    setmode(1'b0, 1'b0, 1'b1);
    send(8'hFF, 8);
    chk(!rx_flag, "R7 edges ignored with enable high", rx_flag, 0);
    @(negedge clk) cs_n = 0;
    repeat (2) @(negedge clk);
    send(8'h3C, 8);
    chk(rx_data == 8'h3C && rx_flag, "R7 shifting with enable low", rx_data, 8'h3C);
    rd();
    send(8'hF0, 5);
    @(negedge clk) cs_n = 1;
    repeat (4) @(negedge clk);
    chk(frame_err == 1'b1, "R8 framing error on early release", frame_err, 1);
    chk(!rx_flag, "R8 partial byte dropped", rx_flag, 0);
    @(negedge clk) cs_n = 0;
    repeat (2) @(negedge clk);
    send(8'hC3, 8);
    chk(rx_data == 8'hC3, "R8 next frame aligned", rx_data, 8'hC3);
    rd();
    cs_n = 1;

    for (int m = 0; m < 4; m++) begin
      logic [7:0] e;
      e = 8'h96 ^ 8'(m * 8'h21);
      setmode(m[1], m[0], 1'b0);
      @(negedge clk) begin tx_data = e; tx_load = 1; end
      @(negedge clk) tx_load = 0;
      chk(tx_ready == 1'b0, "R10 buffer full", tx_ready, 0);
      send(8'h00, 8);
      chk(mo == e, "R10 transmit byte on miso", mo, e);
      chk(tx_ready == 1'b1, "R10 buffer taken", tx_ready, 1);
      rd();
      send(8'h00, 8);
      chk(mo == 8'h00, "R10 empty buffer sends zeros", mo, 0);
      rd();
    end

    finish_up();
  end
endmodule